// File: doc/BRIEF.md
# I2C SCL-Low Timeout Watchdog

This block guards an I2C controller against a bus that stays stuck because the controller itself keeps SCL low for too long. It watches the protocol engine's own SCL pull-down enable, and it counts prescaled ticks while that enable is active and a nonzero limit is programmed. If the count reaches the limit, the block raises a release request that forces the engine to let go of both SCL and SDA. It also sets a sticky error flag for the interrupt logic.

Only the local pull-down counts. A line held low by some other device on the bus is not seen, and SDA is not an input at all. Software clears the flag by writing 1. The release request stays asserted until that clear arrives or the protocol engine is reset, so the engine cannot take the lines back at once. The limit can be rewritten at any time; the new value is used at the next comparison and the count is not restarted.

Top module: `i2c_scl_timeout`

## Requirements
- R1: When `limit` is 0 the watchdog is disabled: the count stays at 0, and `to_flag` and `force_release` never rise no matter how long `scl_drive_low` is held.
- R2: Whenever `scl_drive_low` is 0, the count returns to 0 at the next clock. A later low period starts counting from zero.
- R3: The count advances by one only on a clock where `tick` is 1 and `scl_drive_low` is 1. Cycles without a tick do not advance it, and neither do cycles where the local drive is off (for example when another device holds the line).
- R4: With `tick` high on every cycle from the clock edge that first sees `scl_drive_low`=1, the count equals L after L edges. `to_flag` and `force_release` both become 1 after edge L+1, and not earlier.
- R5: Once `force_release` is set, it stays 1 until a clock with `flag_clr`=1 or `engine_rst`=1. While it is set, the count is held at 0.
- R6: `to_flag` is sticky. It is cleared only by a clock with `flag_clr`=1 (write-one-to-clear), and `engine_rst` leaves it unchanged.
- R7: If an expiry and `flag_clr` happen on the same clock, the expiry wins: `to_flag` and `force_release` are both 1 afterwards.
- R8: A change of `limit` while counting takes effect at the next comparison, and the count keeps its value. If the new limit is at or below the current count, the block expires on the next clock.
- R9: After reset, `to_flag`=0, `force_release`=0 and the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_drive_low | input | 1 | The local engine is pulling SCL low |
| tick | input | 1 | Single-cycle prescaler strobe |
| limit | input | TW | Timeout limit in ticks; 0 disables |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| engine_rst | input | 1 | Protocol engine reset; drops the release request |
| force_release | output | 1 | Forces both bus lines released |
| to_flag | output | 1 | Sticky timeout error flag |

## Verification
The hardest case to reach from the ports is an expiry and a flag clear landing on the same clock. That case needs the flag already set while the release request is down. The bench gets there in steps. It first forces one expiry. It then uses the engine reset to drop only the release request. It counts up to the limit again and pulses the clear exactly on the edge where the count meets the limit. Lowering the limit below a running count is the other case that takes careful timing, and the bench reaches it by rewriting the limit in the middle of a low period.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
  localparam int unsigned TMO_W_DEFAULT = 8;

  typedef struct packed {
    logic flag;
    logic hold;
  } tmo_stat_t;
endpackage

// File: rtl/tmo_counter.sv
module tmo_counter #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drive_low,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  input  logic          hold,
  output logic          expire
);
  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt_q, cnt_d;
  logic          armed;
  logic          cnt_en;

  assign armed  = (limit != '0) && drive_low && !hold;
  assign expire = armed && (cnt_q >= limit);
  assign cnt_en = armed && tick && !expire && (cnt_q != CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (!armed)      cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: local release zeroes the count
  p_idle_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_low |=> (cnt_q == '0));

  // R3: no tick, no advance
  p_tick_gates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && drive_low && !hold && limit != '0) |=> $stable(cnt_q));

  // R1: disabled keeps count at zero
  p_disabled_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |=> (cnt_q == '0));

  // R5: count parked while release is held
  p_hold_parks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));
endmodule

// File: rtl/tmo_latch.sv
module tmo_latch
  import i2c_tmo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      expire,
  input  logic      flag_clr,
  input  logic      engine_rst,
  output tmo_stat_t stat
);
  tmo_stat_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (expire) begin
      st_d.flag = 1'b1;
      st_d.hold = 1'b1;
    end else begin
      if (flag_clr)               st_d.flag = 1'b0;
      if (flag_clr || engine_rst) st_d.hold = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign stat = st_q;

  // R6: flag is sticky without a clear
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.flag && !flag_clr) |=> st_q.flag);

  // R5: release held until clear or engine reset
  p_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.hold && !flag_clr && !engine_rst) |=> st_q.hold);

  // R7: expiry beats a clear in the same cycle
  p_expire_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (st_q.flag && st_q.hold));
endmodule

// File: rtl/i2c_scl_timeout.sv
module i2c_scl_timeout
  import i2c_tmo_pkg::*;
#(
  parameter int unsigned TW = TMO_W_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_drive_low,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  input  logic          flag_clr,
  input  logic          engine_rst,
  output logic          force_release,
  output logic          to_flag
);
  logic      expire;
  tmo_stat_t stat;

  tmo_counter #(.TW(TW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .drive_low (scl_drive_low),
    .tick      (tick),
    .limit     (limit),
    .hold      (stat.hold),
    .expire    (expire)
  );

  tmo_latch u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .flag_clr   (flag_clr),
    .engine_rst (engine_rst),
    .stat       (stat)
  );

  assign force_release = stat.hold;
  assign to_flag       = stat.flag;

  // R1: a disabled watchdog never raises a fresh flag
  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0 && !to_flag) |=> !to_flag);

  // R6: clear without expiry drops the flag
  p_clear_works_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !expire) |=> !to_flag);
endmodule

// File: tb/sim_i2c_scl_timeout.sv
module sim_i2c_scl_timeout;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scl_drive_low, tick, flag_clr, engine_rst;
  logic [TW-1:0] limit;
  logic          force_release, to_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  i2c_scl_timeout #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_drive_low(scl_drive_low), .tick(tick),
    .limit(limit), .flag_clr(flag_clr), .engine_rst(engine_rst),
    .force_release(force_release), .to_flag(to_flag)
  );

  // {limit[8], edges[16], expected flag[1]}
  localparam int NV = 9;
  localparam logic [24:0] VEC [NV] = '{
    {8'd0,   16'd40,  1'b0},
    {8'd3,   16'd3,   1'b0},
    {8'd3,   16'd4,   1'b1},
    {8'd1,   16'd1,   1'b0},
    {8'd1,   16'd2,   1'b1},
    {8'd10,  16'd10,  1'b0},
    {8'd10,  16'd11,  1'b1},
    {8'd255, 16'd255, 1'b0},
    {8'd255, 16'd256, 1'b1}
  };

  task automatic chk(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_clear();
    scl_drive_low = 0; tick = 0; flag_clr = 1; engine_rst = 1;
    step(1);
    flag_clr = 0; engine_rst = 0;
    step(1);
  endtask

  initial begin
    rst_n = 0; scl_drive_low = 0; tick = 0; flag_clr = 0; engine_rst = 0; limit = '0;
    step(2);
    // R9: reset state
    chk(to_flag, 1'b0, "R9 flag");
    chk(force_release, 1'b0, "R9 release");
    rst_n = 1;
    step(1);

    // R4 / R1 table walk
    for (int i = 0; i < NV; i++) begin
      idle_clear();
      limit = VEC[i][24:17];
      scl_drive_low = 1; tick = 1;
      step(int'(VEC[i][16:1]));
      chk(to_flag, VEC[i][0], $sformatf("R4/R1 flag vec%0d", i));
      chk(force_release, VEC[i][0], $sformatf("R4/R1 release vec%0d", i));
    end

    // R3: drive low without ticks never expires
    idle_clear();
    limit = 8'd2; scl_drive_low = 1; tick = 0;
    step(30);
    chk(to_flag, 1'b0, "R3 no ticks");
    // R3: ticks with local drive off (external hold) do not count
    scl_drive_low = 0; tick = 1;
    step(30);
    chk(to_flag, 1'b0, "R3 external hold");

    // R2: release resets count
    idle_clear();
    limit = 8'd5; scl_drive_low = 1; tick = 1;
    step(5);
    scl_drive_low = 0; step(1);
    scl_drive_low = 1; step(5);
    chk(to_flag, 1'b0, "R2 restart from zero");
    step(1);
    chk(to_flag, 1'b1, "R2 expiry after full second period");

    // R5: release held, dropped by engine reset; R6 flag kept
    step(10);
    chk(force_release, 1'b1, "R5 release held");
    engine_rst = 1; scl_drive_low = 0; step(1); engine_rst = 0;
    chk(force_release, 1'b0, "R5 engine reset drops release");
    chk(to_flag, 1'b1, "R6 flag survives engine reset");

    // R7: clear coincides with expiry
    limit = 8'd4; scl_drive_low = 1; tick = 1;
    step(4);
    flag_clr = 1; step(1); flag_clr = 0;
    chk(to_flag, 1'b1, "R7 flag after clear+expire");
    chk(force_release, 1'b1, "R7 release after clear+expire");

    // R6: plain clear
    scl_drive_low = 0; flag_clr = 1; step(1); flag_clr = 0;
    chk(to_flag, 1'b0, "R6 clear");
    chk(force_release, 1'b0, "R5 clear drops release");

    // R8: lower limit below running count
    limit = 8'd20; scl_drive_low = 1; tick = 1;
    step(8);
    chk(to_flag, 1'b0, "R8 before change");
    limit = 8'd3; tick = 0; step(1);
    chk(to_flag, 1'b1, "R8 lowered limit expires next clock");

    // R8: raise limit mid-count without restart
    idle_clear();
    limit = 8'd3; scl_drive_low = 1; tick = 1;
    step(2);
    limit = 8'd6; step(4);
    chk(to_flag, 1'b0, "R8 raised limit not yet");
    step(1);
    chk(to_flag, 1'b1, "R8 raised limit kept count");

    // R1: disable mid-count
    idle_clear();
    limit = 8'd4; scl_drive_low = 1; tick = 1;
    step(3);
    limit = 8'd0; step(20);
    chk(to_flag, 1'b0, "R1 disable mid count");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule